// File: doc/BRIEF.md
# UART ring-buffer DMA channel

This block is a single DMA channel that moves bytes between a circular buffer in memory and a UART byte stream. A parameter fixes its direction. A receive channel writes each byte it accepts from the UART into the ring. A transmit channel reads bytes that software has queued in the ring and hands them to the UART.

Both pointers are 17 bits wide: a byte index in bits 15:0 and a wrap flag in bit 16. Because of the wrap flag, a full ring and an empty ring read differently. Software owns one pointer and the hardware owns the other. The occupied count and the free count are derived from the two pointers and can be read back at any time.

Control and status sit behind a small register port that decodes seven address bits. Memory traffic uses a single-beat byte request that is held until it is acknowledged. Stop and flush are handshakes: software writes a control bit and then polls until the channel reports that it is done.

Top module: `uart_ring_dma`

## Requirements
- R1: The write pointer (offset 0x2c) and the read pointer (offset 0x30) hold an index in bits 15:0 and a wrap flag in bit 16. When a pointer advances from index length−1, its index becomes 0 and its wrap flag inverts. Any other advance adds 1 to the index.
- R2: The occupied count (offset 0x3c) is wpt−rpt when the two wrap flags are equal. When they differ it is wpt+length−rpt. The free count (offset 0x40) is length (offset 0x24) minus the occupied count.
- R3: A receive channel accepts a UART byte only when all three hold: it is enabled, stop is clear, and the free count is nonzero. It writes the byte in one beat to base (offset 0x1c) plus the write-pointer index. It advances the write pointer when that beat is acknowledged.
- R4: A transmit channel runs while it is enabled, stop is clear and the occupied count is nonzero. It reads the byte at base plus the read-pointer index, holds that byte on the UART side until the UART accepts it, and then advances the read pointer.
- R5: While stop (offset 0x10, bit 0) is 1, no new beat starts. Once no beat is in flight, enable (offset 0x08, bit 0) clears. Enable stays 0 after stop is written back to 0.
- R6: Writing 1 to bit 0 of the reset register (offset 0x0c) does four things: it clears enable, aborts any beat, clears the flags, and sets the hardware-owned pointer to 0.
- R7: In transmit mode, writing 1 to flush (offset 0x14, bit 0) makes it read 1 until the ring is empty. The hardware then clears it and sets flag bit 0.
- R8: In receive mode, flag bit 0 (offset 0x00) sets while the occupied count is nonzero and at least the threshold (offset 0x28). Flag bit 1 sets on an idle pulse while the occupied count is nonzero. irq is the OR of the flags masked by the enables (offset 0x04). Any write to the flag register clears the flags.
- R9: In transmit mode, flag bit 0 also sets when a sent byte empties the ring. Only interrupt-enable bit 0 exists in this mode, so bit 1 reads 0.
- R10: After reset every register reads 0 and irq is 0. A pointer write takes effect on the next cycle. Enable reads 1 only while the channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Beat acknowledge |
| mem_rdata | input | 8 | Byte read, valid with mem_ack |
| rx_valid | input | 1 | UART offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Channel takes the offered byte |
| rx_idle | input | 1 | UART idle or timeout pulse |
| tx_valid | output | 1 | Channel offers a byte to send |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | UART takes the byte |

## Verification
In receive mode, single bytes are fed in well below the threshold and then up to it. This separates the level-based threshold flag from the idle flag. The ring is then driven past its end to show the index folding back to 0 with an inverted wrap flag, and the occupied count switching to the cross-wrap formula. A full ring is offered a further byte to confirm that the free-count gate holds, and a stopped channel is offered one to confirm that enable gates intake. In transmit mode, a run that ends exactly at the write pointer is compared with a flush issued over a wrapped run, and then with a flush issued on an already empty ring. Together these show that completion depends on the pointers meeting and not on the flush write itself.

// File: rtl/uring_pkg.sv
package uring_pkg;

    localparam int IDX_W = 16;
    localparam int PTR_W = IDX_W + 1;
    localparam int CNT_W = IDX_W + 1;

    localparam logic [6:0] OFS_FLAG  = 7'h00;
    localparam logic [6:0] OFS_INTEN = 7'h04;
    localparam logic [6:0] OFS_EN    = 7'h08;
    localparam logic [6:0] OFS_RST   = 7'h0c;
    localparam logic [6:0] OFS_STOP  = 7'h10;
    localparam logic [6:0] OFS_FLUSH = 7'h14;
    localparam logic [6:0] OFS_BASE  = 7'h1c;
    localparam logic [6:0] OFS_LEN   = 7'h24;
    localparam logic [6:0] OFS_THRE  = 7'h28;
    localparam logic [6:0] OFS_WPT   = 7'h2c;
    localparam logic [6:0] OFS_RPT   = 7'h30;
    localparam logic [6:0] OFS_VALID = 7'h3c;
    localparam logic [6:0] OFS_LEFT  = 7'h40;
    localparam logic [6:0] OFS_DBG   = 7'h50;

    typedef struct packed {
        logic             wrap;
        logic [IDX_W-1:0] idx;
    } ring_ptr_t;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_MEM  = 2'd1,
        MV_SEND = 2'd2
    } mv_state_t;

    // Next position of a ring pointer: fold at len-1 and flip the wrap flag.
    function automatic ring_ptr_t ptr_step(ring_ptr_t p, logic [IDX_W-1:0] len);
        ring_ptr_t n;
        if (p.idx == len - 1'b1) begin
            n.idx  = '0;
            n.wrap = ~p.wrap;
        end else begin
            n.idx  = p.idx + 1'b1;
            n.wrap = p.wrap;
        end
        return n;
    endfunction

    // Bytes held between the consumer and producer pointers.
    function automatic logic [CNT_W-1:0] ring_fill(ring_ptr_t w, ring_ptr_t r,
                                                   logic [IDX_W-1:0] len);
        if (w.wrap == r.wrap)
            return {1'b0, w.idx} - {1'b0, r.idx};
        else
            return {1'b0, w.idx} + {1'b0, len} - {1'b0, r.idx};
    endfunction

endpackage

// File: rtl/uring_ptrs.sv
module uring_ptrs
    import uring_pkg::*;
#(
    parameter bit TX_DIR = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  logic             sw_we,
    input  ring_ptr_t        sw_val,
    input  logic             hw_adv,
    input  logic [IDX_W-1:0] len,
    output ring_ptr_t        wpt,
    output ring_ptr_t        rpt,
    output logic [IDX_W-1:0] hw_idx,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] room
);

    ring_ptr_t sw_q;
    ring_ptr_t hw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
            hw_q <= '0;
        end else begin
            if (sw_we)
                sw_q <= sw_val;
            if (warm_rst)
                hw_q <= '0;
            else if (hw_adv)
                hw_q <= ptr_step(hw_q, len);
        end
    end

    generate
        if (TX_DIR) begin : g_tx
            assign wpt = sw_q;
            assign rpt = hw_q;
        end else begin : g_rx
            assign wpt = hw_q;
            assign rpt = sw_q;
        end
    endgenerate

    assign hw_idx = hw_q.idx;
    assign fill   = ring_fill(wpt, rpt, len);
    assign room   = {1'b0, len} - fill;

    // R1: an advance from the last slot folds the index and flips the wrap flag
    assert_ptr_fold_R1: assert property (@(posedge clk) disable iff (rst)
        (hw_adv && !warm_rst && len != '0 && hw_q.idx == len - 1'b1)
        |=> (hw_q.idx == '0 && hw_q.wrap != $past(hw_q.wrap)));

    // R6: a warm reset leaves the hardware pointer at zero
    assert_warm_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> (hw_q == '0));

endmodule

// File: rtl/uring_mover.sv
module uring_mover
    import uring_pkg::*;
#(
    parameter bit TX_DIR = 1'b0,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  hw_idx,
    input  logic              has_data,
    input  logic              has_room,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              hw_adv,
    output logic              busy,
    output mv_state_t         state_o
);

    mv_state_t  st;
    logic [7:0] byte_q;

    assign mem_addr  = base + ADDR_W'(hw_idx);
    assign mem_req   = (st == MV_MEM);
    assign mem_wdata = byte_q;
    assign busy      = (st != MV_IDLE);
    assign state_o   = st;

    generate
        if (TX_DIR) begin : g_tx
            logic unused_rx_side;
            assign unused_rx_side = rx_valid ^ (^rx_data) ^ has_room;
            assign mem_we   = 1'b0;
            assign rx_ready = 1'b0;
            assign tx_valid = (st == MV_SEND);
            assign tx_data  = byte_q;
            assign hw_adv   = (st == MV_SEND) && tx_ready;

            always_ff @(posedge clk) begin
                if (rst || warm_rst) begin
                    st     <= MV_IDLE;
                    byte_q <= '0;
                end else begin
                    case (st)
                        MV_IDLE: if (go && has_data) st <= MV_MEM;
                        MV_MEM: if (mem_ack) begin
                            byte_q <= mem_rdata;
                            st     <= MV_SEND;
                        end
                        MV_SEND: if (tx_ready) st <= MV_IDLE;
                        default: st <= MV_IDLE;
                    endcase
                end
            end

            // R4: an offered byte stays put until the UART takes it
            assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
                (tx_valid && !tx_ready && !warm_rst) |=> (tx_valid && $stable(tx_data)));
        end else begin : g_rx
            logic unused_tx_side;
            assign unused_tx_side = tx_ready ^ (^mem_rdata) ^ has_data;
            assign mem_we   = (st == MV_MEM);
            assign tx_valid = 1'b0;
            assign tx_data  = '0;
            assign rx_ready = (st == MV_IDLE) && go && has_room;
            assign hw_adv   = (st == MV_MEM) && mem_ack;

            always_ff @(posedge clk) begin
                if (rst || warm_rst) begin
                    st     <= MV_IDLE;
                    byte_q <= '0;
                end else begin
                    case (st)
                        MV_IDLE: if (rx_ready && rx_valid) begin
                            byte_q <= rx_data;
                            st     <= MV_MEM;
                        end
                        MV_MEM: if (mem_ack) st <= MV_IDLE;
                        default: st <= MV_IDLE;
                    endcase
                end
            end

            // R3: every accepted byte turns into a write beat on the next cycle
            assert_rx_to_mem_R3: assert property (@(posedge clk) disable iff (rst)
                (rx_valid && rx_ready && !warm_rst) |=> (mem_req && mem_we));
        end
    endgenerate

    // R3: a pending beat is not withdrawn before it is acknowledged
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !warm_rst) |=> mem_req);

endmodule

// File: rtl/uring_ctrl.sv
module uring_ctrl
    import uring_pkg::*;
#(
    parameter bit TX_DIR = 1'b0,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  ring_ptr_t         wpt,
    input  ring_ptr_t         rpt,
    input  logic [CNT_W-1:0]  fill,
    input  logic [CNT_W-1:0]  room,
    input  logic              busy,
    input  logic              hw_adv,
    input  mv_state_t         state,
    input  logic              rx_idle,
    output logic              go,
    output logic              warm_rst,
    output logic              sw_we,
    output ring_ptr_t         sw_val,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  len
);

    localparam logic [1:0] INTEN_MASK = TX_DIR ? 2'b01 : 2'b11;
    localparam logic [6:0] SW_PTR_OFS = TX_DIR ? OFS_WPT : OFS_RPT;

    logic              en_q, stop_q, flush_q;
    logic [1:0]        inten_q, flag_q, flag_set;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  len_q, thre_q;
    logic              ring_empty, flush_done;

    assign warm_rst   = reg_wr && reg_addr == OFS_RST && reg_wdata[0];
    assign sw_we      = reg_wr && reg_addr == SW_PTR_OFS;
    assign sw_val     = ring_ptr_t'(reg_wdata[PTR_W-1:0]);
    assign go         = en_q && !stop_q;
    assign base       = base_q;
    assign len        = len_q;
    assign ring_empty = (fill == '0);
    assign flush_done = flush_q && ring_empty;

    always_comb begin
        if (TX_DIR) begin
            flag_set = {1'b0, flush_done || (hw_adv && fill == CNT_W'(1))};
        end else begin
            flag_set = {rx_idle && !ring_empty,
                        !ring_empty && fill >= {1'b0, thre_q}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            stop_q  <= 1'b0;
            flush_q <= 1'b0;
            inten_q <= '0;
            flag_q  <= '0;
            base_q  <= '0;
            len_q   <= '0;
            thre_q  <= '0;
        end else begin
            if (warm_rst)
                en_q <= 1'b0;
            else if (stop_q && !busy)
                en_q <= 1'b0;
            else if (reg_wr && reg_addr == OFS_EN && reg_wdata[0] && !stop_q)
                en_q <= 1'b1;

            if (reg_wr && reg_addr == OFS_STOP)
                stop_q <= reg_wdata[0];
            if (reg_wr && reg_addr == OFS_INTEN)
                inten_q <= reg_wdata[1:0] & INTEN_MASK;
            if (reg_wr && reg_addr == OFS_BASE)
                base_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_addr == OFS_LEN)
                len_q <= reg_wdata[IDX_W-1:0];
            if (reg_wr && reg_addr == OFS_THRE)
                thre_q <= reg_wdata[IDX_W-1:0];

            if (!TX_DIR || warm_rst || flush_done)
                flush_q <= 1'b0;
            else if (reg_wr && reg_addr == OFS_FLUSH && reg_wdata[0])
                flush_q <= 1'b1;

            if (warm_rst || (reg_wr && reg_addr == OFS_FLAG))
                flag_q <= '0;
            else
                flag_q <= flag_q | flag_set;
        end
    end

    assign irq = |(flag_q & inten_q);

    always_comb begin
        case (reg_addr)
            OFS_FLAG:  reg_rdata = {30'b0, flag_q};
            OFS_INTEN: reg_rdata = {30'b0, inten_q};
            OFS_EN:    reg_rdata = {31'b0, en_q};
            OFS_STOP:  reg_rdata = {31'b0, stop_q};
            OFS_FLUSH: reg_rdata = {31'b0, flush_q};
            OFS_BASE:  reg_rdata = 32'(base_q);
            OFS_LEN:   reg_rdata = 32'(len_q);
            OFS_THRE:  reg_rdata = 32'(thre_q);
            OFS_WPT:   reg_rdata = 32'(wpt);
            OFS_RPT:   reg_rdata = 32'(rpt);
            OFS_VALID: reg_rdata = 32'(fill);
            OFS_LEFT:  reg_rdata = 32'(room);
            OFS_DBG:   reg_rdata = {27'b0, flush_q, stop_q, en_q, 2'(state)};
            default:   reg_rdata = '0;
        endcase
    end

    // R5: with stop set and nothing in flight, the channel goes inactive
    assert_stop_drain_R5: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !busy && !warm_rst) |=> !en_q);

    // R7: flush only drops once the ring has drained (or on a warm reset)
    assert_flush_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_q) |-> ($past(ring_empty) || $past(warm_rst)));

    // R8: a write to the flag register leaves no flag pending
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_FLAG) |=> (flag_q == '0));

endmodule

// File: rtl/uart_ring_dma.sv
module uart_ring_dma
    import uring_pkg::*;
#(
    parameter bit TX_DIR = 1'b0,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              rx_idle,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);

    ring_ptr_t         wpt, rpt, sw_val;
    logic [IDX_W-1:0]  hw_idx, len;
    logic [CNT_W-1:0]  fill, room;
    logic [ADDR_W-1:0] base;
    logic              go, warm_rst, sw_we, hw_adv, busy;
    mv_state_t         state;

    uring_ctrl #(.TX_DIR(TX_DIR), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .wpt(wpt), .rpt(rpt), .fill(fill), .room(room),
        .busy(busy), .hw_adv(hw_adv), .state(state), .rx_idle(rx_idle),
        .go(go), .warm_rst(warm_rst), .sw_we(sw_we), .sw_val(sw_val),
        .base(base), .len(len)
    );

    uring_ptrs #(.TX_DIR(TX_DIR)) u_ptrs (
        .clk(clk), .rst(rst), .warm_rst(warm_rst),
        .sw_we(sw_we), .sw_val(sw_val), .hw_adv(hw_adv), .len(len),
        .wpt(wpt), .rpt(rpt), .hw_idx(hw_idx), .fill(fill), .room(room)
    );

    uring_mover #(.TX_DIR(TX_DIR), .ADDR_W(ADDR_W)) u_mover (
        .clk(clk), .rst(rst), .warm_rst(warm_rst), .go(go),
        .base(base), .hw_idx(hw_idx),
        .has_data(fill != '0), .has_room(room != '0),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .hw_adv(hw_adv), .busy(busy), .state_o(state)
    );

endmodule

// File: tb/uart_ring_dma_bench.sv
module uart_ring_dma_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // receive-direction instance (a_*)
    logic        a_reg_wr = 0;
    logic [6:0]  a_reg_addr = 0;
    logic [31:0] a_reg_wdata = 0, a_reg_rdata;
    logic        a_irq, a_mem_req, a_mem_we, a_mem_ack = 0;
    logic [31:0] a_mem_addr;
    logic [7:0]  a_mem_wdata, a_tx_data;
    logic        a_rx_valid = 0, a_rx_ready, a_rx_idle = 0, a_tx_valid;
    logic [7:0]  a_rx_data = 0;

    // transmit-direction instance (b_*)
    logic        b_reg_wr = 0;
    logic [6:0]  b_reg_addr = 0;
    logic [31:0] b_reg_wdata = 0, b_reg_rdata;
    logic        b_irq, b_mem_req, b_mem_we, b_mem_ack = 0;
    logic [31:0] b_mem_addr;
    logic [7:0]  b_mem_wdata, b_mem_rdata = 0, b_tx_data;
    logic        b_rx_ready, b_tx_valid, b_tx_ready = 0;

    uart_ring_dma #(.TX_DIR(1'b0)) u_uart_ring_dma (
        .clk(clk), .rst(rst), .reg_wr(a_reg_wr), .reg_addr(a_reg_addr),
        .reg_wdata(a_reg_wdata), .reg_rdata(a_reg_rdata), .irq(a_irq),
        .mem_req(a_mem_req), .mem_we(a_mem_we), .mem_addr(a_mem_addr),
        .mem_wdata(a_mem_wdata), .mem_ack(a_mem_ack), .mem_rdata(8'h00),
        .rx_valid(a_rx_valid), .rx_data(a_rx_data), .rx_ready(a_rx_ready),
        .rx_idle(a_rx_idle), .tx_valid(a_tx_valid), .tx_data(a_tx_data),
        .tx_ready(1'b0)
    );

    uart_ring_dma #(.TX_DIR(1'b1)) u_uart_ring_dma_tx (
        .clk(clk), .rst(rst), .reg_wr(b_reg_wr), .reg_addr(b_reg_addr),
        .reg_wdata(b_reg_wdata), .reg_rdata(b_reg_rdata), .irq(b_irq),
        .mem_req(b_mem_req), .mem_we(b_mem_we), .mem_addr(b_mem_addr),
        .mem_wdata(b_mem_wdata), .mem_ack(b_mem_ack), .mem_rdata(b_mem_rdata),
        .rx_valid(1'b0), .rx_data(8'h00), .rx_ready(b_rx_ready),
        .rx_idle(1'b0), .tx_valid(b_tx_valid), .tx_data(b_tx_data),
        .tx_ready(b_tx_ready)
    );

    logic [39:0] rx_q[$];   // expected {address, byte} of receive write beats
    logic [7:0]  tx_q[$];   // expected bytes on the transmit side
    logic [7:0]  bmem [0:255];
    int          rx_idx = 0;
    int          tx_idx = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input bit tx, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        if (tx) begin b_reg_wr = 1; b_reg_addr = a; b_reg_wdata = d; end
        else    begin a_reg_wr = 1; a_reg_addr = a; a_reg_wdata = d; end
        @(negedge clk);
        a_reg_wr = 0;
        b_reg_wr = 0;
    endtask

    task automatic reg_read(input bit tx, input logic [6:0] a, output logic [31:0] d);
        if (tx) b_reg_addr = a; else a_reg_addr = a;
        #1;
        d = tx ? b_reg_rdata : a_reg_rdata;
    endtask

    task automatic expect_reg(input bit tx, input logic [6:0] a, input logic [31:0] exp,
                              input string req);
        logic [31:0] v;
        reg_read(tx, a, v);
        check(req, v, exp);
    endtask

    // UART receive driver: push the expected beat, then hand the byte over.
    task automatic rx_send(input logic [7:0] d);
        rx_q.push_back({32'h40 + 32'(rx_idx), d});
        rx_idx = (rx_idx + 1) % 8;
        @(negedge clk);
        a_rx_valid = 1;
        a_rx_data  = d;
        #1;
        while (!a_rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        a_rx_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tx_expect(input int n);
        for (int i = 0; i < n; i++) begin
            tx_q.push_back(bmem[8'h80 + 8'(tx_idx)]);
            tx_idx = (tx_idx + 1) % 4;
        end
    endtask

    // memory responder and write monitor for the receive instance
    always @(negedge clk) begin
        if (a_mem_ack) a_mem_ack = 0;
        else if (a_mem_req) begin
            a_mem_ack = 1;
            if (a_mem_we) begin
                if (rx_q.size() == 0) check("R3 unexpected write", {24'b0, a_mem_wdata}, 32'hffff);
                else begin
                    logic [39:0] e;
                    e = rx_q.pop_front();
                    check("R3 beat address", a_mem_addr, e[39:8]);
                    check("R3 beat data", {24'b0, a_mem_wdata}, {24'b0, e[7:0]});
                end
            end
        end
    end

    // memory responder for the transmit instance
    always @(negedge clk) begin
        if (b_mem_ack) b_mem_ack = 0;
        else if (b_mem_req) begin
            b_mem_ack   = 1;
            b_mem_rdata = bmem[b_mem_addr[7:0]];
        end
    end

    // UART transmit monitor
    always @(negedge clk) begin
        if (b_tx_ready) b_tx_ready = 0;
        else if (b_tx_valid) begin
            b_tx_ready = 1;
            if (tx_q.size() == 0) check("R4 unexpected byte", {24'b0, b_tx_data}, 32'hffff);
            else check("R4 sent byte", {24'b0, b_tx_data}, {24'b0, tx_q.pop_front()});
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        bit saw;
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i ^ 8'h5a);
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: reset state
        expect_reg(0, 7'h08, 0, "R10 rx enable after reset");
        expect_reg(0, 7'h2c, 0, "R10 rx wpt after reset");
        expect_reg(1, 7'h30, 0, "R10 tx rpt after reset");
        check("R10 irq after reset", {31'b0, a_irq | b_irq}, 0);

        // receive channel setup
        reg_write(0, 7'h1c, 32'h40);
        reg_write(0, 7'h24, 8);
        reg_write(0, 7'h28, 4);
        reg_write(0, 7'h04, 3);
        reg_write(0, 7'h08, 1);
        expect_reg(0, 7'h08, 1, "R10 enable reads 1 when active");

        rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
        expect_reg(0, 7'h2c, 3, "R3 wpt after three bytes");
        expect_reg(0, 7'h3c, 3, "R2 occupied count");
        expect_reg(0, 7'h40, 5, "R2 free count");
        check("R8 no irq below threshold", {31'b0, a_irq}, 0);

        @(negedge clk); a_rx_idle = 1;
        @(negedge clk); a_rx_idle = 0;
        expect_reg(0, 7'h00, 2, "R8 idle flag");
        check("R8 irq on idle", {31'b0, a_irq}, 1);
        reg_write(0, 7'h00, 0);
        expect_reg(0, 7'h00, 0, "R8 flag clear");
        check("R8 irq after clear", {31'b0, a_irq}, 0);

        rx_send(8'h44);
        expect_reg(0, 7'h00, 1, "R8 threshold flag");

        reg_write(0, 7'h30, 4);
        expect_reg(0, 7'h3c, 0, "R10 pointer write next cycle");
        reg_write(0, 7'h00, 0);

        for (int i = 0; i < 6; i++) rx_send(8'h50 + 8'(i));
        expect_reg(0, 7'h2c, 32'h10002, "R1 wpt wrapped");
        expect_reg(0, 7'h3c, 6, "R2 occupied across wrap");
        expect_reg(0, 7'h40, 2, "R2 free across wrap");

        rx_send(8'h60); rx_send(8'h61);
        expect_reg(0, 7'h3c, 8, "R2 full count");
        expect_reg(0, 7'h40, 0, "R2 full free");

        saw = 0;
        @(negedge clk); a_rx_valid = 1; a_rx_data = 8'hee;
        for (int i = 0; i < 5; i++) begin #1; if (a_rx_ready) saw = 1; @(negedge clk); end
        a_rx_valid = 0;
        check("R3 no intake when full", {31'b0, saw}, 0);
        expect_reg(0, 7'h2c, 32'h10004, "R3 wpt held when full");

        reg_write(0, 7'h10, 1);
        repeat (2) @(negedge clk);
        expect_reg(0, 7'h08, 0, "R5 enable clears on stop");
        reg_write(0, 7'h10, 0);
        reg_write(0, 7'h30, 32'h10004);
        saw = 0;
        @(negedge clk); a_rx_valid = 1;
        for (int i = 0; i < 5; i++) begin #1; if (a_rx_ready) saw = 1; @(negedge clk); end
        a_rx_valid = 0;
        check("R5 no intake after stop", {31'b0, saw}, 0);
        expect_reg(0, 7'h08, 0, "R5 enable stays 0");

        reg_write(0, 7'h08, 1);
        expect_reg(0, 7'h08, 1, "R10 re-enable");
        reg_write(0, 7'h0c, 1);
        expect_reg(0, 7'h08, 0, "R6 warm reset clears enable");
        expect_reg(0, 7'h2c, 0, "R6 warm reset clears hw pointer");
        check("R3 all receive beats seen", rx_q.size(), 0);

        // transmit channel
        reg_write(1, 7'h1c, 32'h80);
        reg_write(1, 7'h24, 4);
        reg_write(1, 7'h04, 3);
        expect_reg(1, 7'h04, 1, "R9 tx has one enable bit");
        reg_write(1, 7'h08, 1);
        tx_expect(3);
        reg_write(1, 7'h2c, 3);
        repeat (40) @(negedge clk);
        expect_reg(1, 7'h30, 3, "R4 rpt after run");
        expect_reg(1, 7'h3c, 0, "R4 ring drained");
        expect_reg(1, 7'h00, 1, "R9 empty flag");
        check("R9 irq on empty", {31'b0, b_irq}, 1);
        reg_write(1, 7'h00, 0);
        check("R9 irq cleared", {31'b0, b_irq}, 0);

        tx_expect(2);
        reg_write(1, 7'h2c, 32'h10001);
        expect_reg(1, 7'h3c, 2, "R2 tx occupied across wrap");
        reg_write(1, 7'h14, 1);
        expect_reg(1, 7'h14, 1, "R7 flush pending");
        repeat (40) @(negedge clk);
        expect_reg(1, 7'h14, 0, "R7 flush done");
        expect_reg(1, 7'h00, 1, "R7 flush flag");
        expect_reg(1, 7'h30, 32'h10001, "R1 tx rpt wrapped");

        reg_write(1, 7'h00, 0);
        reg_write(1, 7'h14, 1);
        repeat (3) @(negedge clk);
        expect_reg(1, 7'h14, 0, "R7 flush on empty ring");
        expect_reg(1, 7'h00, 1, "R7 flag on empty flush");
        check("R4 all bytes sent", tx_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule